// File: doc/BRIEF.md
# Machine-Mode Interrupt Entry Unit

This block sits beside a simple in-order core and decides when a device interrupt is taken. It watches a small set of device request lines, keeps the machine-mode control registers for interrupts, and gives the core a one-cycle redirect (target address plus strobe) when execution must move to the handler or back from it. Interrupts are taken only at an instruction boundary, which the core marks with a retire strobe that carries the address of the next instruction.

Taking an interrupt is one atomic step at a single clock edge. The cause register gets the winning source's bit. The next-instruction address is saved as the exception PC. The global enable is cleared. The redirect goes to the trap-vector address. A trap-return strobe sets the global enable again and redirects to the saved exception PC. Software reaches the registers through a CSR port with three operations: write, read, and swap. A swap returns the old contents and stores the new value in the same cycle.

CSR select codes: 0 status, 1 source enable, 2 pending, 3 cause, 4 exception PC, 5 trap vector, 6 scratch. Code 7 reads as zero. Operation codes: 0 idle, 1 write, 2 read, 3 swap. In the status register, bit 0 is the global enable and every other bit reads 0. The enable, pending and cause registers hold source i in bit i, zero-extended.

Top module: `mint_entry_unit`

## Requirements
- R1: After reset, the registers hold these values. Global enable, source enables, pending and cause read 0. The trap vector reads the parameter TVEC_RST. `redir_vld` is 0.
- R2: Pending bit i equals `irq_req[i]` as sampled at the previous clock edge. CSR writes and swaps to pending (select 2) have no effect.
- R3: An interrupt is taken only in a cycle where all of these hold: `retire_vld` is 1, the global enable is 1, and some source has both its pending and enable bits set. If any of these is missing, there is no redirect in the next cycle.
- R4: When several sources qualify, the lowest-numbered one wins. Cause becomes the one-hot bit of the winner.
- R5: On a taken interrupt, the exception PC becomes the `retire_next_pc` of that cycle.
- R6: A taken interrupt clears the global enable. Further retires take nothing until the enable is set again.
- R7: In the cycle after a take, `redir_vld` is 1 for exactly one cycle. `redir_pc` in that cycle equals the trap vector held at the time of the take.
- R8: In the cycle after `trap_ret`, `redir_vld` is 1, `redir_pc` is the exception PC held when `trap_ret` was seen, and the global enable is 1. If `trap_ret` and a qualifying retire arrive in the same cycle, the return wins and no interrupt is taken.
- R9: With operation read (2), `csr_rdata` shows the selected register in the same cycle. With operations idle (0) or write (1), `csr_rdata` is 0. A write takes effect at the next edge.
- R10: With operation swap (3), `csr_rdata` shows the register's old value, and the write data is stored at the same edge.
- R11: Writes to scratch are read back unchanged and affect no other register or output.
- R12: If an interrupt is taken in a cycle that also writes status, cause or exception PC through the CSR port, the values from the interrupt take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Device request lines, level |
| retire_vld | input | 1 | An instruction completes this cycle |
| retire_next_pc | input | XLEN | Address of the instruction after the retiring one |
| trap_ret | input | 1 | Return from the handler |
| csr_op | input | 2 | CSR operation: 0 idle, 1 write, 2 read, 3 swap |
| csr_sel | input | 3 | CSR select code |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (old value on a swap) |
| redir_vld | output | 1 | Redirect strobe, one cycle |
| redir_pc | output | XLEN | Redirect target |

## Verification
The request pattern is varied in several ways. Two enabled sources are raised together to show that the lowest index wins. A source that is pending but not enabled is raised to show that masking applies. Requests are also held while the global enable is clear, and held with no retire strobe, so that each missing take condition is tested on its own. Collisions are tried as well: a trap return together with a qualifying retire, and a take in the same cycle as CSR writes to status, cause and exception PC. These show which event wins each register. Scratch, trap-vector and pending registers are written and swapped to separate stored, ignored, and old-versus-new read data.

// File: rtl/mint_pkg.sv
`timescale 1ns/1ps
package mint_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_SWAP  = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_ENAB = 3'd1,
    SEL_PEND = 3'd2,
    SEL_CAUS = 3'd3,
    SEL_EPC  = 3'd4,
    SEL_TVEC = 3'd5,
    SEL_SCRT = 3'd6,
    SEL_NONE = 3'd7
  } csr_sel_e;

  localparam int unsigned GIE_BIT = 0;

endpackage

// File: rtl/mint_prio.sv
`timescale 1ns/1ps
// Fixed-priority picker: lowest index wins.
module mint_prio #(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [N_SRC-1:0] grant
);

  logic [N_SRC:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N_SRC];

endmodule

// File: rtl/mint_csr_bank.sv
`timescale 1ns/1ps
module mint_csr_bank #(
  parameter int unsigned          N_SRC    = 4,
  parameter int unsigned          XLEN     = 32,
  parameter logic [XLEN-1:0]      TVEC_RST = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       csr_op,
  input  logic [2:0]       csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             take,
  input  logic [N_SRC-1:0] take_grant,
  input  logic [XLEN-1:0]  take_pc,
  input  logic             trap_ret,
  output logic             gie_q,
  output logic [N_SRC-1:0] enab_q,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] cause_q,
  output logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  tvec_q,
  output logic [XLEN-1:0]  scratch_q,
  output logic [XLEN-1:0]  csr_rdata
);
  import mint_pkg::*;

  localparam int unsigned PADW = XLEN - N_SRC;

  csr_op_e  op;
  csr_sel_e sel;
  logic     wr_en;
  logic     rd_en;

  logic             gie_d;
  logic [N_SRC-1:0] enab_d;
  logic [N_SRC-1:0] cause_d;
  logic [XLEN-1:0]  epc_d;
  logic [XLEN-1:0]  tvec_d;
  logic [XLEN-1:0]  scratch_d;

  assign op    = csr_op_e'(csr_op);
  assign sel   = csr_sel_e'(csr_sel);
  assign wr_en = (op == OP_WRITE) || (op == OP_SWAP);
  assign rd_en = (op == OP_READ)  || (op == OP_SWAP);

  // Next state: software write first, then trap entry/return override.
  always_comb begin
    gie_d     = gie_q;
    enab_d    = enab_q;
    cause_d   = cause_q;
    epc_d     = epc_q;
    tvec_d    = tvec_q;
    scratch_d = scratch_q;
    if (wr_en) begin
      case (sel)
        SEL_STAT: gie_d     = csr_wdata[GIE_BIT];
        SEL_ENAB: enab_d    = csr_wdata[N_SRC-1:0];
        SEL_CAUS: cause_d   = csr_wdata[N_SRC-1:0];
        SEL_EPC:  epc_d     = csr_wdata;
        SEL_TVEC: tvec_d    = csr_wdata;
        SEL_SCRT: scratch_d = csr_wdata;
        default:  ;
      endcase
    end
    if (trap_ret) begin
      gie_d = 1'b1;
    end else if (take) begin
      gie_d   = 1'b0;
      cause_d = take_grant;
      epc_d   = take_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q     <= 1'b0;
      enab_q    <= '0;
      pend_q    <= '0;
      cause_q   <= '0;
      epc_q     <= '0;
      tvec_q    <= TVEC_RST;
      scratch_q <= '0;
    end else begin
      gie_q     <= gie_d;
      enab_q    <= enab_d;
      pend_q    <= irq_req;
      cause_q   <= cause_d;
      epc_q     <= epc_d;
      tvec_q    <= tvec_d;
      scratch_q <= scratch_d;
    end
  end

  // Read mux returns pre-edge contents, which is the swap's old value.
  always_comb begin
    csr_rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_STAT: csr_rdata[GIE_BIT] = gie_q;
        SEL_ENAB: csr_rdata = {{PADW{1'b0}}, enab_q};
        SEL_PEND: csr_rdata = {{PADW{1'b0}}, pend_q};
        SEL_CAUS: csr_rdata = {{PADW{1'b0}}, cause_q};
        SEL_EPC:  csr_rdata = epc_q;
        SEL_TVEC: csr_rdata = tvec_q;
        SEL_SCRT: csr_rdata = scratch_q;
        default:  csr_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mint_redirect.sv
`timescale 1ns/1ps
module mint_redirect #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            trap_ret,
  input  logic [XLEN-1:0] tvec,
  input  logic [XLEN-1:0] epc,
  output logic            redir_vld,
  output logic [XLEN-1:0] redir_pc
);

  logic            vld_d;
  logic            pc_en;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    vld_d = take | trap_ret;
    pc_en = vld_d;
    pc_d  = trap_ret ? epc : tvec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      redir_vld <= vld_d;
      if (pc_en) begin
        redir_pc <= pc_d;
      end
    end
  end

endmodule

// File: rtl/mint_entry_unit.sv
`timescale 1ns/1ps
module mint_entry_unit #(
  parameter int unsigned     N_SRC    = 4,
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] TVEC_RST = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             retire_vld,
  input  logic [XLEN-1:0]  retire_next_pc,
  input  logic             trap_ret,
  input  logic [1:0]       csr_op,
  input  logic [2:0]       csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             redir_vld,
  output logic [XLEN-1:0]  redir_pc
);

  logic             gie_q;
  logic [N_SRC-1:0] enab_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] cause_q;
  logic [XLEN-1:0]  epc_q;
  logic [XLEN-1:0]  tvec_q;
  logic [XLEN-1:0]  scratch_q;

  logic [N_SRC-1:0] ready;
  logic [N_SRC-1:0] grant;
  logic             any_ready;
  logic             take;

  assign ready = pend_q & enab_q;

  mint_prio #(.N_SRC(N_SRC)) u_prio (
    .req   (ready),
    .any   (any_ready),
    .grant (grant)
  );

  // Boundary-only entry; a return in the same cycle suppresses entry.
  assign take = retire_vld & gie_q & any_ready & ~trap_ret;

  mint_csr_bank #(
    .N_SRC    (N_SRC),
    .XLEN     (XLEN),
    .TVEC_RST (TVEC_RST)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_op     (csr_op),
    .csr_sel    (csr_sel),
    .csr_wdata  (csr_wdata),
    .irq_req    (irq_req),
    .take       (take),
    .take_grant (grant),
    .take_pc    (retire_next_pc),
    .trap_ret   (trap_ret),
    .gie_q      (gie_q),
    .enab_q     (enab_q),
    .pend_q     (pend_q),
    .cause_q    (cause_q),
    .epc_q      (epc_q),
    .tvec_q     (tvec_q),
    .scratch_q  (scratch_q),
    .csr_rdata  (csr_rdata)
  );

  mint_redirect #(.XLEN(XLEN)) u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .trap_ret  (trap_ret),
    .tvec      (tvec_q),
    .epc       (epc_q),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc)
  );

endmodule

// File: rtl/mint_entry_sva.sv
`timescale 1ns/1ps
module mint_entry_sva #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned XLEN  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_vld,
  input logic [XLEN-1:0]  retire_next_pc,
  input logic             trap_ret,
  input logic [1:0]       csr_op,
  input logic [2:0]       csr_sel,
  input logic [XLEN-1:0]  csr_wdata,
  input logic             redir_vld,
  input logic [XLEN-1:0]  redir_pc,
  input logic             take,
  input logic             gie_q,
  input logic [N_SRC-1:0] cause_q,
  input logic [XLEN-1:0]  epc_q,
  input logic [XLEN-1:0]  tvec_q,
  input logic [XLEN-1:0]  scratch_q
);

  a_r3_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_vld && !trap_ret) |=> !redir_vld);

  a_r3_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !trap_ret) |=> !redir_vld);

  a_r4_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(cause_q) == 1));

  a_r5_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(retire_next_pc)));

  a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

  a_r7_vector_jump: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redir_vld && redir_pc == $past(tvec_q)));

  a_r8_return_jump: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ret |=> (redir_vld && gie_q && redir_pc == $past(epc_q)));

  a_r10_swap_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == 2'd3 && csr_sel == 3'd6) |=> (scratch_q == $past(csr_wdata)));

endmodule

bind mint_entry_unit mint_entry_sva #(.N_SRC(N_SRC), .XLEN(XLEN)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .retire_vld     (retire_vld),
  .retire_next_pc (retire_next_pc),
  .trap_ret       (trap_ret),
  .csr_op         (csr_op),
  .csr_sel        (csr_sel),
  .csr_wdata      (csr_wdata),
  .redir_vld      (redir_vld),
  .redir_pc       (redir_pc),
  .take           (take),
  .gie_q          (gie_q),
  .cause_q        (cause_q),
  .epc_q          (epc_q),
  .tvec_q         (tvec_q),
  .scratch_q      (scratch_q)
);

// File: tb/mint_entry_unit_tb.sv
`timescale 1ns/1ps
module mint_entry_unit_tb;

  localparam int          N    = 4;
  localparam int          XL   = 32;
  localparam logic [31:0] TVR  = 32'h0000_0100;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_req;
  logic          retire_vld;
  logic [XL-1:0] retire_next_pc;
  logic          trap_ret;
  logic [1:0]    csr_op;
  logic [2:0]    csr_sel;
  logic [XL-1:0] csr_wdata;
  logic [XL-1:0] csr_rdata;
  logic          redir_vld;
  logic [XL-1:0] redir_pc;

  mint_entry_unit #(.N_SRC(N), .XLEN(XL), .TVEC_RST(TVR)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .retire_vld(retire_vld),
    .retire_next_pc(retire_next_pc), .trap_ret(trap_ret), .csr_op(csr_op),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redir_vld(redir_vld), .redir_pc(redir_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp;
  int n_bad;
  bit done;

  // Reference model state
  bit          m_gie;
  bit [N-1:0]  m_enab, m_pend, m_cause;
  bit [31:0]   m_epc, m_tvec, m_scr, m_rpc;
  bit          m_rv;

  task automatic model_reset();
    m_gie = 0; m_enab = 0; m_pend = 0; m_cause = 0;
    m_epc = 0; m_tvec = TVR; m_scr = 0; m_rv = 0; m_rpc = 0;
  endtask

  function automatic bit [31:0] model_read(input bit [1:0] op, input bit [2:0] sel);
    if (op != 2 && op != 3) return 32'd0;
    case (sel)
      3'd0: return {31'd0, m_gie};
      3'd1: return {28'd0, m_enab};
      3'd2: return {28'd0, m_pend};
      3'd3: return {28'd0, m_cause};
      3'd4: return m_epc;
      3'd5: return m_tvec;
      3'd6: return m_scr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit [1:0] op, input bit [2:0] sel, input bit [31:0] wd,
                      input bit [N-1:0] irq, input bit rv, input bit [31:0] npc,
                      input bit tr, input string tag);
    bit          take;
    bit          old_gie;
    bit [N-1:0]  ready;
    bit [N-1:0]  win;
    bit [31:0]   old_tvec, old_epc;
    @(negedge clk);
    csr_op = op; csr_sel = sel; csr_wdata = wd; irq_req = irq;
    retire_vld = rv; retire_next_pc = npc; trap_ret = tr;
    #1;
    check(tag, "csr_rdata", csr_rdata, model_read(op, sel));
    check(tag, "redir_vld", {31'd0, redir_vld}, {31'd0, m_rv});
    if (m_rv) check(tag, "redir_pc", redir_pc, m_rpc);
    @(posedge clk);
    old_gie = m_gie; old_tvec = m_tvec; old_epc = m_epc;
    ready = m_pend & m_enab;
    win = 0;
    for (int i = 0; i < N; i++) if (ready[i] && win == 0) win[i] = 1'b1;
    take = rv && old_gie && (ready != 0) && !tr;
    if (op == 1 || op == 3) begin
      case (sel)
        3'd0: m_gie = wd[0];
        3'd1: m_enab = wd[N-1:0];
        3'd3: m_cause = wd[N-1:0];
        3'd4: m_epc = wd;
        3'd5: m_tvec = wd;
        3'd6: m_scr = wd;
        default: ;
      endcase
    end
    m_pend = irq;
    m_rv = 0;
    if (tr) begin
      m_gie = 1; m_rv = 1; m_rpc = old_epc;
    end else if (take) begin
      m_gie = 0; m_cause = win; m_epc = npc; m_rv = 1; m_rpc = old_tvec;
    end
  endtask

  task automatic rd(input bit [2:0] sel, input bit [N-1:0] irq, input string tag);
    step(2'd2, sel, 32'd0, irq, 1'b0, 32'd0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 0; irq_req = 0; retire_vld = 0; retire_next_pc = 0; trap_ret = 0;
    csr_op = 0; csr_sel = 0; csr_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset contents
    for (int s = 0; s < 8; s++) rd(3'(s), 4'h0, "R1");

    // R9/R11: write then read; idle op reads 0
    step(2'd1, 3'd5, 32'h0000_2000, 4'h0, 0, 0, 0, "R9");
    step(2'd1, 3'd6, 32'hCAFE_0001, 4'h0, 0, 0, 0, "R11");
    step(2'd0, 3'd6, 32'h0, 4'h0, 0, 0, 0, "R9");
    rd(3'd5, 4'h0, "R9");
    rd(3'd6, 4'h0, "R11");
    rd(3'd0, 4'h0, "R11");
    // R10: swap returns old, stores new
    step(2'd3, 3'd6, 32'h1234_5678, 4'h0, 0, 0, 0, "R10");
    step(2'd3, 3'd6, 32'h0BAD_F00D, 4'h0, 0, 0, 0, "R10");
    rd(3'd6, 4'h0, "R10");

    // R2: pending follows lines, writes ignored
    step(2'd1, 3'd2, 32'hF, 4'h5, 0, 0, 0, "R2");
    rd(3'd2, 4'h5, "R2");
    step(2'd3, 3'd2, 32'h0, 4'h0, 0, 0, 0, "R2");
    rd(3'd2, 4'h0, "R2");

    // R3: enables set, gie clear -> no take
    step(2'd1, 3'd1, 32'h6, 4'h0, 0, 0, 0, "R3");
    step(2'd0, 3'd0, 32'h0, 4'h6, 0, 0, 0, "R3");
    step(2'd0, 3'd0, 32'h0, 4'h6, 1, 32'h40, 0, "R3");
    // gie set, no retire -> no take
    step(2'd1, 3'd0, 32'h1, 4'h6, 0, 0, 0, "R3");
    step(2'd0, 3'd0, 32'h0, 4'h6, 0, 32'h44, 0, "R3");
    // R4/R5/R6/R7: retire with sources 1 and 2 qualifying
    step(2'd0, 3'd0, 32'h0, 4'h6, 1, 32'h48, 0, "R4");
    rd(3'd3, 4'h6, "R4");
    rd(3'd4, 4'h6, "R5");
    rd(3'd0, 4'h6, "R6");
    step(2'd0, 3'd0, 32'h0, 4'h6, 1, 32'h4C, 0, "R6");
    step(2'd0, 3'd0, 32'h0, 4'h6, 0, 0, 0, "R7");

    // R8: return alone, then return colliding with qualifying retire
    step(2'd0, 3'd0, 32'h0, 4'h4, 0, 0, 1, "R8");
    rd(3'd0, 4'h4, "R8");
    step(2'd0, 3'd0, 32'h0, 4'h4, 1, 32'h80, 1, "R8");
    rd(3'd3, 4'h4, "R8");

    // R3: source 3 pending but masked, source 2 only enabled later
    step(2'd1, 3'd1, 32'h1, 4'h8, 0, 0, 0, "R3");
    step(2'd0, 3'd0, 32'h0, 4'h8, 1, 32'h90, 0, "R3");
    step(2'd0, 3'd0, 32'h0, 4'h8, 0, 0, 0, "R3");

    // R12: take with same-cycle CSR writes
    step(2'd1, 3'd1, 32'hC, 4'h8, 0, 0, 0, "R12");
    step(2'd1, 3'd3, 32'h1, 4'hC, 1, 32'hA0, 0, "R12");
    rd(3'd3, 4'hC, "R12");
    step(2'd1, 3'd0, 32'h1, 4'hC, 0, 0, 1, "R12");
    step(2'd1, 3'd4, 32'h5555, 4'hC, 1, 32'hB0, 0, "R12");
    rd(3'd4, 4'hC, "R12");
    step(2'd0, 3'd0, 32'h0, 4'hC, 0, 0, 1, "R12");
    step(2'd1, 3'd0, 32'h1, 4'hC, 1, 32'hC0, 0, "R12");
    rd(3'd0, 4'h0, "R12");
    rd(3'd3, 4'h0, "R4");
    rd(3'd7, 4'h0, "R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule